// File: doc/BRIEF.md
# DDR3 Command Timing Guard

This block sits between a DDR3 command sequencer and the memory pins of a single rank with eight banks. Each memory clock it decodes the command on the active-low chip select, row strobe, column strobe and write enable lines, together with the bank and address lines. It tracks the minimum spacings, in clock cycles, that the memory needs between commands. Some of these spacings belong to one bank: activate to column access, activate to precharge, precharge to activate, and activate to activate on the same bank. Others apply across the whole device: activate to activate on any bank, the rolling window that allows only a few activates, the refresh recovery time and the mode-register recovery times.

For the command currently presented, a combinational ready flag states whether that command would be legal in this cycle. The sequencer can hold the command back until the flag is high. If an illegal command is driven anyway, a one-cycle violation pulse and a cause code appear on the following cycle. Only legal commands update the tracked state, so the tracking always describes what a compliant memory would see. Every spacing is a module parameter.

Top module: `ddr3_cmd_guard`

## Requirements
- R1: Decoding uses {ras_n,cas_n,we_n} while cs_n is low: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 ZQ calibration. cs_n high is a deselect. No-op and deselect are always ready and never flagged.
- R2: A read or write to a bank is illegal until TRCD cycles (default 14) after that bank's activate. Cause code 5.
- R3: A precharge of an open bank is illegal until TRAS cycles (default 36) after its activate. Cause code 6.
- R4: An activate to a bank is illegal until TRP cycles (default 14) after that bank was precharged. Cause code 7.
- R5: Two activates to the same bank must be at least TRC cycles apart (default 50). Cause code 8.
- R6: Two activates to any banks must be at least TRRD cycles apart (default 6). Cause code 9.
- R7: An activate is illegal if the FAW_ACTS-th most recent legal activate (default 4) is fewer than TFAW cycles old (default 27). Cause code 10.
- R8: For TRFC cycles after a refresh (default 279), every command other than no-op or deselect is illegal. Cause code 1.
- R9: After a mode register set, another mode register set needs TMRD cycles (default 4). Any other command needs TMOD cycles (default 12). Cause code 2.
- R10: A read, a write or a single-bank precharge (address bit 10 low) to a closed bank gets cause code 3. An activate to an open bank gets code 4. A precharge with address bit 10 high closes every bank and restarts the precharge time of every bank. It is illegal (code 6) while any open bank is still younger than TRAS.
- R11: cmd_ok is high in the same cycle exactly when the presented command is legal. On the next cycle, viol_pulse is high with viol_code holding the cause for an illegal command; otherwise viol_pulse is low and viol_code is 0. When several causes apply, the one listed first wins, in this order: 1, 2, 3 or 4, 5 or 6, 7, 8, 9, 10.
- R12: After reset every bank is closed, every spacing has expired and viol_pulse is low.
- R13: A flagged command changes no tracked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address; bit AP_BIT selects all-bank precharge |
| cmd_ok | output | 1 | Presented command is legal this cycle |
| viol_pulse | output | 1 | Previous cycle's command was illegal |
| viol_code | output | 4 | Cause of that violation, 0 when none |

## Verification
The bench keeps every default spacing except the row-cycle time, which it raises to 60. This pushes the row-cycle time above the sum of the open time and the precharge time. Without that change, the row-cycle rule could never be the first cause to bind. All other limits stay at their defaults and are short enough that the bench can step to each boundary, one cycle early and exactly on time. This includes the full refresh recovery. A long random command stream then drives the priority order and the all-bank precharge through combinations that the directed cases do not reach.

// File: rtl/ddr3_guard_pkg.sv
`timescale 1ns/1ps
package ddr3_guard_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
      CMD_PRE, CMD_REF, CMD_MRS, CMD_ZQ
   } cmd_e;

   typedef enum logic [3:0] {
      V_NONE  = 4'd0,  V_RFC  = 4'd1, V_MODE = 4'd2, V_NOROW = 4'd3,
      V_OPEN  = 4'd4,  V_RCD  = 4'd5, V_RAS  = 4'd6, V_RP    = 4'd7,
      V_RC    = 4'd8,  V_RRD  = 4'd9, V_FAW  = 4'd10
   } viol_e;

   function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
      if (cs_n) return CMD_DESEL;
      case ({ras_n, cas_n, we_n})
         3'b111:  return CMD_NOP;
         3'b011:  return CMD_ACT;
         3'b101:  return CMD_RD;
         3'b100:  return CMD_WR;
         3'b010:  return CMD_PRE;
         3'b001:  return CMD_REF;
         3'b000:  return CMD_MRS;
         default: return CMD_ZQ;
      endcase
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr3_span_timer.sv
`timescale 1ns/1ps
module ddr3_span_timer #(
   parameter int unsigned W    = 9,
   parameter int unsigned SPAN = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   generate
      if (SPAN <= 1) begin : g_trivial
         logic unused_trivial_ins;
         assign unused_trivial_ins = clk ^ rst_n ^ start;
         assign expired = 1'b1;
      end else begin : g_count
         if ((1 << W) <= SPAN - 1) begin : g_bad_w
            $fatal(1, "ddr3_span_timer: width too small for span");
         end
         logic [W-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)          remain <= '0;
            else if (start)      remain <= W'(SPAN - 1);
            else if (remain != 0) remain <= remain - 1'b1;
         end
         assign expired = (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/ddr3_bank_track.sv
`timescale 1ns/1ps
module ddr3_bank_track #(
   parameter int unsigned W    = 9,
   parameter int unsigned TRCD = 14,
   parameter int unsigned TRAS = 36,
   parameter int unsigned TRP  = 14,
   parameter int unsigned TRC  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic pre,
   output logic is_open,
   output logic rcd_ok,
   output logic ras_ok,
   output logic rp_ok,
   output logic rc_ok
);
   always_ff @(posedge clk) begin
      if (!rst_n)   is_open <= 1'b0;
      else if (act) is_open <= 1'b1;
      else if (pre) is_open <= 1'b0;
   end

   ddr3_span_timer #(.W(W), .SPAN(TRCD)) u_rcd (.clk(clk), .rst_n(rst_n), .start(act), .expired(rcd_ok));
   ddr3_span_timer #(.W(W), .SPAN(TRAS)) u_ras (.clk(clk), .rst_n(rst_n), .start(act), .expired(ras_ok));
   ddr3_span_timer #(.W(W), .SPAN(TRC))  u_rc  (.clk(clk), .rst_n(rst_n), .start(act), .expired(rc_ok));
   ddr3_span_timer #(.W(W), .SPAN(TRP))  u_rp  (.clk(clk), .rst_n(rst_n), .start(pre), .expired(rp_ok));
endmodule

// File: rtl/ddr3_act_window.sv
`timescale 1ns/1ps
module ddr3_act_window #(
   parameter int unsigned W     = 9,
   parameter int unsigned TRRD  = 6,
   parameter int unsigned TFAW  = 27,
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   output logic rrd_ok,
   output logic faw_ok
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [PTR_W-1:0] oldest;
   logic [DEPTH-1:0] slot_free;

   ddr3_span_timer #(.W(W), .SPAN(TRRD)) u_rrd (.clk(clk), .rst_n(rst_n), .start(act), .expired(rrd_ok));

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         ddr3_span_timer #(.W(W), .SPAN(TFAW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .start(act && (oldest == PTR_W'(i))),
            .expired(slot_free[i]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) oldest <= '0;
      else if (act) oldest <= (oldest == PTR_W'(DEPTH - 1)) ? '0 : oldest + 1'b1;
   end

   assign faw_ok = slot_free[oldest];
endmodule

// File: rtl/ddr3_cmd_guard.sv
`timescale 1ns/1ps
module ddr3_cmd_guard
   import ddr3_guard_pkg::*;
#(
   parameter int unsigned BA_W     = 3,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned AP_BIT   = 10,
   parameter int unsigned TRCD     = 14,
   parameter int unsigned TRAS     = 36,
   parameter int unsigned TRP      = 14,
   parameter int unsigned TRC      = 50,
   parameter int unsigned TRRD     = 6,
   parameter int unsigned TFAW     = 27,
   parameter int unsigned FAW_ACTS = 4,
   parameter int unsigned TRFC     = 279,
   parameter int unsigned TMRD     = 4,
   parameter int unsigned TMOD     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_ok,
   output logic              viol_pulse,
   output logic [3:0]        viol_code
);
   localparam int unsigned BANKS = 1 << BA_W;
   localparam int unsigned TMAX  = max2(max2(max2(TRCD, TRAS), max2(TRP, TRC)),
                                        max2(max2(TRRD, TFAW), max2(TRFC, max2(TMRD, TMOD))));
   localparam int unsigned CNT_W = $clog2(TMAX + 1);

   generate
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $fatal(1, "ddr3_cmd_guard: AP_BIT outside address");
      end
      if (FAW_ACTS < 1) begin : g_bad_faw
         $fatal(1, "ddr3_cmd_guard: FAW_ACTS must be at least 1");
      end
   endgenerate

   cmd_e  cmd;
   viol_e cause;
   logic  all_bank;
   logic  unused_addr_bits;
   logic  take_act, take_pre, take_ref, take_mrs;
   logic  rfc_ok, mrd_ok, mod_ok, rrd_ok, faw_ok;
   logic [BANKS-1:0] open_v, rcd_v, ras_v, rp_v, rc_v;
   logic  all_ras_ok;

   assign cmd              = decode_cmd(cs_n, ras_n, cas_n, we_n);
   assign all_bank         = addr[AP_BIT];
   assign unused_addr_bits = ^addr;

   assign take_act = cmd_ok && (cmd == CMD_ACT);
   assign take_pre = cmd_ok && (cmd == CMD_PRE);
   assign take_ref = cmd_ok && (cmd == CMD_REF);
   assign take_mrs = cmd_ok && (cmd == CMD_MRS);

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         ddr3_bank_track #(.W(CNT_W), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .TRC(TRC)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act(take_act && (ba == BA_W'(b))),
            .pre(take_pre && (all_bank || (ba == BA_W'(b)))),
            .is_open(open_v[b]), .rcd_ok(rcd_v[b]), .ras_ok(ras_v[b]),
            .rp_ok(rp_v[b]), .rc_ok(rc_v[b]));
      end
   endgenerate

   ddr3_act_window #(.W(CNT_W), .TRRD(TRRD), .TFAW(TFAW), .DEPTH(FAW_ACTS)) u_window (
      .clk(clk), .rst_n(rst_n), .act(take_act), .rrd_ok(rrd_ok), .faw_ok(faw_ok));

   ddr3_span_timer #(.W(CNT_W), .SPAN(TRFC)) u_rfc (.clk(clk), .rst_n(rst_n), .start(take_ref), .expired(rfc_ok));
   ddr3_span_timer #(.W(CNT_W), .SPAN(TMRD)) u_mrd (.clk(clk), .rst_n(rst_n), .start(take_mrs), .expired(mrd_ok));
   ddr3_span_timer #(.W(CNT_W), .SPAN(TMOD)) u_mod (.clk(clk), .rst_n(rst_n), .start(take_mrs), .expired(mod_ok));

   assign all_ras_ok = &(~open_v | ras_v);

   // Cause selection: refresh recovery, mode recovery, bank state, then spacings.
   always_comb begin
      cause = V_NONE;
      if (cmd != CMD_DESEL && cmd != CMD_NOP) begin
         if (!rfc_ok)                                     cause = V_RFC;
         else if ((cmd == CMD_MRS) ? !mrd_ok : !mod_ok)   cause = V_MODE;
         else begin
            case (cmd)
               CMD_ACT: begin
                  if (open_v[ba])      cause = V_OPEN;
                  else if (!rp_v[ba])  cause = V_RP;
                  else if (!rc_v[ba])  cause = V_RC;
                  else if (!rrd_ok)    cause = V_RRD;
                  else if (!faw_ok)    cause = V_FAW;
               end
               CMD_RD, CMD_WR: begin
                  if (!open_v[ba])     cause = V_NOROW;
                  else if (!rcd_v[ba]) cause = V_RCD;
               end
               CMD_PRE: begin
                  if (all_bank) begin
                     if (!all_ras_ok)  cause = V_RAS;
                  end else if (!open_v[ba]) cause = V_NOROW;
                  else if (!ras_v[ba])      cause = V_RAS;
               end
               default: cause = V_NONE;
            endcase
         end
      end
   end

   assign cmd_ok = (cause == V_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_pulse <= 1'b0;
         viol_code  <= 4'd0;
      end else begin
         viol_pulse <= !cmd_ok;
         viol_code  <= cause;
      end
   end
endmodule

// File: rtl/ddr3_cmd_guard_chk.sv
`timescale 1ns/1ps
module ddr3_cmd_guard_chk #(
   parameter int unsigned BA_W = 3,
   parameter int unsigned TRRD = 6,
   parameter int unsigned TRFC = 279,
   parameter int unsigned TMRD = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic [BA_W-1:0] ba,
   input logic            cmd_ok,
   input logic            viol_pulse,
   input logic [3:0]      viol_code
);
   logic issued, is_act, is_ref, is_mrs;
   logic unused_ba;
   assign unused_ba = ^ba;
   assign issued = !cs_n && !(ras_n && cas_n && we_n);
   assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
   assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !issued |=> (!viol_pulse && viol_code == 4'd0));

   p_flag_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && !cmd_ok) |=> (viol_pulse && viol_code != 4'd0));

   p_clean_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok |=> (!viol_pulse && viol_code == 4'd0));

   p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_code <= 4'd10);

   p_rrd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((TRRD > 1) && is_act && cmd_ok) |=> !(is_act && cmd_ok));

   p_rfc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((TRFC > 1) && is_ref && cmd_ok) |=> !(issued && cmd_ok));

   p_mrd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((TMRD > 1) && is_mrs && cmd_ok) |=> !(is_mrs && cmd_ok));
endmodule

bind ddr3_cmd_guard ddr3_cmd_guard_chk #(.BA_W(BA_W), .TRRD(TRRD), .TRFC(TRFC), .TMRD(TMRD)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .ba(ba), .cmd_ok(cmd_ok), .viol_pulse(viol_pulse), .viol_code(viol_code));

// File: tb/ddr3_cmd_guard_test.sv
`timescale 1ns/1ps
module ddr3_cmd_guard_test;
   localparam int TRCD = 14, TRAS = 36, TRP = 14, TRC = 60, TRRD = 6;
   localparam int TFAW = 27, FAW_N = 4, TRFC = 279, TMRD = 4, TMOD = 12;
   localparam int LIMIT = 150000;
   localparam int K_DES = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4;
   localparam int K_PRE = 5, K_REF = 6, K_MRS = 7, K_ZQ = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0] ba = '0;
   logic [15:0] addr = '0;
   logic cmd_ok, viol_pulse;
   logic [3:0] viol_code;

   int nchk = 0, nfail = 0, cyc = 0;
   int last_act[8], last_pre[8];
   bit open_b[8];
   int last_any, last_ref, last_mrs;
   int acts[$];
   bit done = 0;

   always #2.5 clk = ~clk;

   ddr3_cmd_guard #(.TRC(TRC)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .cmd_ok(cmd_ok), .viol_pulse(viol_pulse), .viol_code(viol_code));

   task automatic chk(input bit good, input string req, input int act, input int exp);
      nchk++;
      if (!good) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int model_code(input int k, input int b, input bit ap);
      if (k == K_DES || k == K_NOP) return 0;
      if (cyc - last_ref < TRFC) return 1;
      if (k == K_MRS ? (cyc - last_mrs < TMRD) : (cyc - last_mrs < TMOD)) return 2;
      if (k == K_ACT) begin
         if (open_b[b]) return 4;
         if (cyc - last_pre[b] < TRP) return 7;
         if (cyc - last_act[b] < TRC) return 8;
         if (cyc - last_any < TRRD) return 9;
         if (acts.size() >= FAW_N && cyc - acts[acts.size() - FAW_N] < TFAW) return 10;
      end else if (k == K_RD || k == K_WR) begin
         if (!open_b[b]) return 3;
         if (cyc - last_act[b] < TRCD) return 5;
      end else if (k == K_PRE) begin
         if (ap) begin
            for (int i = 0; i < 8; i++)
               if (open_b[i] && cyc - last_act[i] < TRAS) return 6;
         end else begin
            if (!open_b[b]) return 3;
            if (cyc - last_act[b] < TRAS) return 6;
         end
      end
      return 0;
   endfunction

   function automatic void model_take(input int k, input int b, input bit ap);
      case (k)
         K_ACT: begin
            open_b[b] = 1; last_act[b] = cyc; last_any = cyc;
            acts.push_back(cyc);
            if (acts.size() > FAW_N) void'(acts.pop_front());
         end
         K_PRE: for (int i = 0; i < 8; i++)
                   if (ap || i == b) begin open_b[i] = 0; last_pre[i] = cyc; end
         K_REF: last_ref = cyc;
         K_MRS: last_mrs = cyc;
         default: ;
      endcase
   endfunction

   task automatic step(input int k, input int b, input bit ap);
      int exp_code;
      @(negedge clk);
      cs_n = (k == K_DES);
      case (k)
         K_DES:   {ras_n, cas_n, we_n} = 3'b000;
         K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
         K_RD:    {ras_n, cas_n, we_n} = 3'b101;
         K_WR:    {ras_n, cas_n, we_n} = 3'b100;
         K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
         K_REF:   {ras_n, cas_n, we_n} = 3'b001;
         K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
         K_ZQ:    {ras_n, cas_n, we_n} = 3'b110;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
      ba = 3'(b);
      addr = ap ? 16'h0400 : 16'h0000;
      #1;
      exp_code = model_code(k, b, ap);
      chk(cmd_ok === (exp_code == 0), "R11 ready", int'(cmd_ok), int'(exp_code == 0));
      @(posedge clk); #1;
      chk(viol_pulse === (exp_code != 0) && viol_code === 4'(exp_code),
          "R11 flag/code", int'(viol_code), exp_code);
      if (exp_code == 0) model_take(k, b, ap);
      cyc++;
   endtask

   task automatic idle_to(input int target);
      while (cyc < target) step(K_NOP, 0, 0);
   endtask

   task automatic code_is(input int exp, input string req);
      chk(viol_code === 4'(exp), req, int'(viol_code), exp);
   endtask

   initial begin
      #(LIMIT * 5);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int t0, ta, tp, tm, tr;
      for (int i = 0; i < 8; i++) begin last_act[i] = -100000; last_pre[i] = -100000; open_b[i] = 0; end
      last_any = -100000; last_ref = -100000; last_mrs = -100000;
      repeat (4) @(posedge clk);
      #1;
      chk(viol_pulse === 1'b0, "R12 pulse low in reset", int'(viol_pulse), 0);
      @(negedge clk); rst_n = 1'b1;
      step(K_NOP, 0, 0); code_is(0, "R12 no flag after reset");

      // R12 / R6 / R7: activates straight from reset, then spacing limits
      t0 = cyc;
      step(K_ACT, 0, 0); code_is(0, "R12 activate ready from reset");
      idle_to(t0 + 5);  step(K_ACT, 1, 0); code_is(9, "R6 activate one cycle early");
      step(K_ACT, 1, 0); code_is(0, "R6 activate on time");
      idle_to(t0 + 12); step(K_ACT, 2, 0);
      idle_to(t0 + 18); step(K_ACT, 3, 0);
      idle_to(t0 + 26); step(K_ACT, 4, 0); code_is(10, "R7 fifth activate inside window");
      step(K_ACT, 4, 0); code_is(0, "R7 fifth activate at window edge");
      ta = t0 + 27;
      step(K_ACT, 5, 0); code_is(9, "R13 flagged activate");
      step(K_RD, 5, 0);  code_is(3, "R13 flagged activate left bank closed");

      // R2 / R3 / R4 / R5 on bank 4
      idle_to(ta + 13); step(K_RD, 4, 0); code_is(5, "R2 read one cycle early");
      step(K_RD, 4, 0); code_is(0, "R2 read on time");
      step(K_WR, 4, 0); code_is(0, "R2 write after spacing");
      idle_to(ta + 35); step(K_PRE, 4, 0); code_is(6, "R3 precharge one cycle early");
      step(K_PRE, 4, 0); code_is(0, "R3 precharge on time");
      tp = ta + 36;
      idle_to(tp + 13); step(K_ACT, 4, 0); code_is(7, "R4 activate before precharge time");
      step(K_ACT, 4, 0); code_is(8, "R5 activate before row cycle");
      idle_to(ta + 60); step(K_ACT, 4, 0); code_is(0, "R5 activate at row cycle");

      // R10: bank state
      step(K_ACT, 0, 0); code_is(4, "R10 activate to open bank");
      step(K_PRE, 5, 0); code_is(3, "R10 precharge to closed bank");
      step(K_PRE, 0, 1); code_is(6, "R10 all-bank precharge with young bank");
      idle_to(ta + 96); step(K_PRE, 0, 1); code_is(0, "R10 all-bank precharge");
      step(K_RD, 2, 0); code_is(3, "R10 read after all-bank precharge");

      // R9: mode register recovery
      tm = cyc;
      step(K_MRS, 0, 0); code_is(0, "R9 first mode set");
      idle_to(tm + 3); step(K_MRS, 1, 0); code_is(2, "R9 mode set early");
      step(K_MRS, 1, 0); code_is(0, "R9 mode set on time");
      tm = tm + 4;
      step(K_DES, 0, 0); code_is(0, "R1 deselect during recovery");
      step(K_NOP, 0, 0); code_is(0, "R1 no-op during recovery");
      idle_to(tm + 11); step(K_ZQ, 0, 1); code_is(2, "R9 calibration early");
      step(K_ZQ, 0, 1); code_is(0, "R9 calibration on time");

      // R8 / R11: refresh recovery and priority
      tr = cyc;
      step(K_REF, 0, 0); code_is(0, "R8 refresh accepted");
      step(K_ACT, 6, 0); code_is(1, "R8 activate during refresh");
      step(K_MRS, 0, 0); code_is(1, "R11 refresh cause outranks mode");
      idle_to(tr + 278); step(K_RD, 1, 0); code_is(1, "R11 refresh cause outranks closed bank");
      step(K_ACT, 6, 0); code_is(0, "R8 activate after refresh recovery");

      // random stream compared against the model every cycle
      for (int n = 0; n < 5000; n++) begin
         int r, k, sub;
         r = $urandom_range(0, 9);
         if (r < 5) k = K_NOP;
         else if (r == 5) k = K_ACT;
         else if (r == 6) k = K_RD;
         else if (r == 7) k = K_WR;
         else if (r == 8) k = K_PRE;
         else begin
            sub = $urandom_range(0, 15);
            k = (sub == 0) ? K_REF : (sub < 5) ? K_MRS : (sub < 9) ? K_ZQ : K_DES;
         end
         step(k, $urandom_range(0, 7), ($urandom_range(0, 7) == 0));
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule